// File: doc/BRIEF.md
# Asynchronous static RAM port controller

This block connects a clocked host to an external asynchronous static RAM of 64K words by 16 bits. The host sends one word-wide request at a time over a valid/ready handshake. A request carries a word address, write data, a two-bit byte-enable and a direction flag. The controller runs the memory-side timing and returns a one-clock response pulse. For a read, that pulse carries the captured data. For a write, it marks the release of the write strobe.

The memory side has these signals:
- active-low chip select, output enable and write enable;
- a lower-byte strobe and an upper-byte strobe, both active low;
- the address lines;
- a shared data bus, split into an outgoing word, a driver enable and an incoming word. The tristate buffer itself sits outside the block.

Every memory-side output comes from a flop. Every phase of an access lasts a whole number of clocks. The read wait, the write pulse and the read-to-next-access turnaround are parameters. Their defaults suit the fastest memory grade at a 100 MHz clock.

Back-pressure rules:
- `req_ready` is high only when no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The host must hold its request fields stable while `req_valid` is high and `req_ready` is low.
- The response has no ready signal. `rsp_valid` stays high for exactly one clock and the host must take it then.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is applied and on the first clock after it, `req_ready` is high, `rsp_valid` is low, chip select, output enable, write enable and both byte strobes are high, and the data driver enable is low.
- R2: A read is accepted on edge A. The controller drives chip select and output enable low and leaves write enable high. It captures the bus on edge A+RD_WAIT. `rsp_valid` and `rsp_rdata` are visible in the clock that follows that edge.
- R3: A write is accepted on edge A. Output enable stays high for the whole access. Write enable is low for exactly WR_PULSE clocks. The data driver is on for every clock that write enable is low and for one clock after it rises. `rsp_valid` is visible in the clock after edge A+WR_PULSE.
- R4: Byte-enable bit 0 drives the lower strobe, which gates data bits 7:0. Byte-enable bit 1 drives the upper strobe, which gates bits 15:8. A write changes only the bytes whose enable is 1.
- R5: In `rsp_rdata`, a byte whose enable was 0 reads as zero. A write with both enables 0 leaves the memory word unchanged, and a read with both enables 0 returns zero.
- R6: The data driver is never on while output enable is low. After a read, output enable is high for at least TURN_CYC+1 clocks before the driver turns on.
- R7: Only one access is outstanding at a time. `req_ready` is low from acceptance until the clock after edge A+RD_WAIT+TURN_CYC for a read, and until the clock after edge A+WR_PULSE+1 for a write.
- R8: Each output-enable low phase lasts at least T_AA_PS. Each write-enable low phase lasts at least T_WP_PS. Before the driver turns on, output enable has been high for at least T_HZ_PS. All three are measured as clock count times CLK_PS.
- R9: `rsp_valid` is high for one clock per access and never while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data with disabled bytes zeroed |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lb_n | output | 1 | Lower-byte strobe, active low |
| mem_ub_n | output | 1 | Upper-byte strobe, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | 16 | Data read from the memory bus |

## Verification
Two events can meet in one cycle: the end of a read, when output enable is released, and the acceptance of a following write, which turns on the bus driver. The random stream sends reads and writes back to back with no idle gap, and a directed read-then-write pair targets this case. A bus monitor judges the result on every clock. It flags any clock where the driver is on while output enable is low. It also counts the clocks with output enable high before each driver turn-on and compares that count with the turnaround figure. Acceptance timing is checked separately, by the clock on which `req_ready` returns.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_WRITE = 3'd3,
    ST_WREC  = 3'd4
  } asram_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_lane_map.sv
module asram_lane_map #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] strb_n
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign strb_n[i] = ~be[i];
  end

endmodule

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2,
  parameter int CNT_W    = 1,
  parameter int RD_WAIT  = 1,
  parameter int WR_PULSE = 1,
  parameter int TURN_CYC = 1,
  parameter int CLK_PS   = 10000,
  parameter int T_AA_PS  = 8000,
  parameter int T_WP_PS  = 6000,
  parameter int T_HZ_PS  = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_strb_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_strb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_zero
);

  localparam int LANE_W = DATA_W / LANES;
  localparam int CHK_W  = 8;

  asram_state_e      state_q;
  logic              cs_n_q, oe_n_q, we_n_q, dq_oe_q, rsp_q;
  logic [LANES-1:0]  strb_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_o_q, rdata_q;
  logic [DATA_W-1:0] lane_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign lane_mask[i*LANE_W +: LANE_W] = {LANE_W{~strb_n_q[i]}};
  end

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (state_q == ST_IDLE && req_valid) begin
      cnt_load = 1'b1;
      cnt_val  = req_write ? CNT_W'(WR_PULSE - 1) : CNT_W'(RD_WAIT - 1);
    end else if (state_q == ST_READ && cnt_zero) begin
      cnt_load = 1'b1;
      cnt_val  = CNT_W'(TURN_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      strb_n_q <= '1;
      dq_oe_q  <= 1'b0;
      rsp_q    <= 1'b0;
      addr_q   <= '0;
      dq_o_q   <= '0;
      rdata_q  <= '0;
    end else begin
      rsp_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q   <= req_addr;
            cs_n_q   <= 1'b0;
            strb_n_q <= req_strb_n;
            if (req_write) begin
              we_n_q  <= 1'b0;
              oe_n_q  <= 1'b1;
              dq_oe_q <= 1'b1;
              dq_o_q  <= req_wdata;
              state_q <= ST_WRITE;
            end else begin
              oe_n_q  <= 1'b0;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (cnt_zero) begin
            rdata_q  <= mem_dq_i & lane_mask;
            rsp_q    <= 1'b1;
            cs_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            strb_n_q <= '1;
            state_q  <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (cnt_zero) state_q <= ST_IDLE;
        end
        ST_WRITE: begin
          if (cnt_zero) begin
            we_n_q   <= 1'b1;
            cs_n_q   <= 1'b1;
            strb_n_q <= '1;
            rsp_q    <= 1'b1;
            state_q  <= ST_WREC;
          end
        end
        ST_WREC: begin
          dq_oe_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_cs_n   = cs_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_strb_n = strb_n_q;
  assign mem_addr   = addr_q;
  assign mem_dq_o   = dq_o_q;
  assign mem_dq_oe  = dq_oe_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  // Phase-length counters used only by the timing assertions below.
  logic [CHK_W-1:0] oe_lo_cnt, we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_lo_cnt <= '0;
      we_lo_cnt <= '0;
      oe_hi_cnt <= '0;
    end else begin
      oe_lo_cnt <= !oe_n_q ? ((oe_lo_cnt == '1) ? oe_lo_cnt : oe_lo_cnt + 1'b1) : '0;
      we_lo_cnt <= !we_n_q ? ((we_lo_cnt == '1) ? we_lo_cnt : we_lo_cnt + 1'b1) : '0;
      oe_hi_cnt <=  oe_n_q ? ((oe_hi_cnt == '1) ? oe_hi_cnt : oe_hi_cnt + 1'b1) : '0;
    end
  end

  p_read_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (int'(oe_lo_cnt) * CLK_PS >= T_AA_PS));

  p_write_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(we_lo_cnt) * CLK_PS >= T_WP_PS));

  p_release_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (int'(oe_hi_cnt) * CLK_PS >= T_HZ_PS));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  p_driver_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 10000,
  parameter int T_AA_PS  = 8000,
  parameter int T_WP_PS  = 6000,
  parameter int T_HZ_PS  = 4000,
  parameter int RD_WAIT  = 1,
  parameter int WR_PULSE = 1,
  parameter int TURN_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_i
);

  localparam int LANES   = DATA_W / 8;
  localparam int MAX_CNT = max3(RD_WAIT, WR_PULSE, TURN_CYC);
  localparam int CNT_W   = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);

  logic [LANES-1:0] req_strb_n;
  logic [LANES-1:0] strb_n;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  asram_lane_map #(.LANES(LANES)) u_lane_map (
    .be     (req_be),
    .strb_n (req_strb_n)
  );

  asram_wait_cnt #(.W(CNT_W)) u_wait_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  asram_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LANES    (LANES),
    .CNT_W    (CNT_W),
    .RD_WAIT  (RD_WAIT),
    .WR_PULSE (WR_PULSE),
    .TURN_CYC (TURN_CYC),
    .CLK_PS   (CLK_PS),
    .T_AA_PS  (T_AA_PS),
    .T_WP_PS  (T_WP_PS),
    .T_HZ_PS  (T_HZ_PS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_strb_n (req_strb_n),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_strb_n (strb_n),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_i   (mem_dq_i),
    .cnt_load   (cnt_load),
    .cnt_val    (cnt_val),
    .cnt_zero   (cnt_zero)
  );

  assign mem_lb_n = strb_n[0];
  assign mem_ub_n = strb_n[LANES-1];

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int RDW = 1;
  localparam int WPL = 1;
  localparam int TAC = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_addr, mem_dq_o;
  logic [15:0] mem_dq_i = 16'h5A5A;

  always #5 clk = ~clk;

  asram_ctrl #(.RD_WAIT(RDW), .WR_PULSE(WPL), .TURN_CYC(TAC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] sram [int];
  logic [15:0] expd [int];

  function automatic logic [15:0] seed_word(input int a);
    return 16'(a * 40503) ^ 16'h5AC3;
  endfunction

  function automatic logic [15:0] sram_rd(input int a);
    if (sram.exists(a)) return sram[a];
    return seed_word(a);
  endfunction

  function automatic logic [15:0] exp_rd(input int a);
    if (expd.exists(a)) return expd[a];
    return seed_word(a);
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] be);
    return (o & ~lane_mask(be)) | (n & lane_mask(be));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model and bus monitor, evaluated away from the active edge.
  bit          pend_act = 1'b0;
  int          pend_addr;
  logic [15:0] pend_data;
  logic [1:0]  pend_be;
  int          oe_hi = 100;
  logic        dq_oe_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_act && (mem_we_n || mem_cs_n)) begin
        sram[pend_addr] = merge(sram_rd(pend_addr), pend_data, pend_be);
        pend_act = 1'b0;
      end
      if (!mem_cs_n && !mem_we_n) begin
        pend_act  = 1'b1;
        pend_addr = int'(mem_addr);
        pend_data = mem_dq_o;
        pend_be   = {~mem_ub_n, ~mem_lb_n};
        if (!mem_dq_oe) chk(1'b0, "R3", "driver off during write", 0, 1);
        if (!mem_oe_n)  chk(1'b0, "R3", "oe low during write", 0, 1);
      end
      if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R6", "bus contention", 1, 0);
      if (mem_dq_oe && !dq_oe_prev)
        chk(oe_hi >= TAC + 1, "R6", "quiet clocks before drive", oe_hi, TAC + 1);
      oe_hi = mem_oe_n ? ((oe_hi < 100) ? oe_hi + 1 : oe_hi) : 0;
      dq_oe_prev = mem_dq_oe;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
        logic [15:0] w;
        w = sram_rd(int'(mem_addr));
        mem_dq_i = {mem_ub_n ? 8'hEE : w[15:8], mem_lb_n ? 8'hEE : w[7:0]};
      end else begin
        mem_dq_i = 16'h5A5A;
      end
    end
  end

  // Call at a negedge; returns at a negedge with req_ready high.
  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    logic [15:0] expv;
    int idx;
    int exp_ready;
    expv = lane_mask(be) & exp_rd(int'(a));
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7", "ready low after accept", req_ready, 0);
    idx = 1;
    while (!rsp_valid && idx < 50) begin
      @(negedge clk);
      idx++;
    end
    if (wr) begin
      chk(idx - 1 == WPL, "R3", "write ack latency", idx - 1, WPL);
      expd[int'(a)] = merge(exp_rd(int'(a)), d, be);
    end else begin
      chk(idx - 1 == RDW, "R2", "read ack latency", idx - 1, RDW);
      chk(rsp_rdata == expv, tag, "read data", rsp_rdata, expv);
    end
    exp_ready = wr ? (WPL + 2) : (RDW + TAC + 1);
    @(negedge clk);
    idx++;
    chk(!rsp_valid, "R9", "ack one clock", rsp_valid, 0);
    while (!req_ready && idx < 60) begin
      @(negedge clk);
      idx++;
    end
    chk(idx == exp_ready, "R7", "ready return clock", idx, exp_ready);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] pool [6];
    pool = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8000, 16'h00FF, 16'h7FFE};
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && mem_cs_n && mem_oe_n && mem_we_n &&
        mem_lb_n && mem_ub_n && !mem_dq_oe, "R1", "in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && mem_cs_n && mem_oe_n && mem_we_n &&
        mem_lb_n && mem_ub_n && !mem_dq_oe, "R1", "after reset", 0, 0);

    // Directed corners
    do_op(1'b0, 16'h0000, 16'h0000, 2'b11, "R2");
    do_op(1'b1, 16'h0000, 16'hA1B2, 2'b11, "R3");
    do_op(1'b0, 16'h0000, 16'h0000, 2'b11, "R2");
    do_op(1'b1, 16'h0000, 16'hFFC4, 2'b01, "R4");
    do_op(1'b0, 16'h0000, 16'h0000, 2'b11, "R4");
    do_op(1'b1, 16'h0000, 16'h77FF, 2'b10, "R4");
    do_op(1'b0, 16'h0000, 16'h0000, 2'b11, "R4");
    do_op(1'b0, 16'h0000, 16'h0000, 2'b01, "R5");
    do_op(1'b0, 16'h0000, 16'h0000, 2'b10, "R5");
    do_op(1'b1, 16'h0000, 16'h1111, 2'b00, "R5");
    do_op(1'b0, 16'h0000, 16'h0000, 2'b11, "R5");
    do_op(1'b0, 16'h0000, 16'h0000, 2'b00, "R5");
    do_op(1'b1, 16'hFFFF, 16'h5EED, 2'b11, "R3");
    do_op(1'b0, 16'hFFFF, 16'h0000, 2'b11, "R2");
    do_op(1'b1, 16'hFFFF, 16'h0102, 2'b11, "R6");

    // Random stream
    for (int i = 0; i < 300; i++) begin
      bit          wr;
      logic [15:0] a, d;
      logic [1:0]  be;
      wr = 1'($urandom);
      a  = pool[$urandom % 6];
      d  = 16'($urandom);
      be = 2'($urandom);
      do_op(wr, a, d, be, wr ? "R4" : "R5");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule